// File: doc/BRIEF.md
# DMA Address and Word-Count Generator

This block produces the memory address sequence and tracks the number of words for one DMA channel. It holds an address counter, a word counter, a saved initial value for each of them, and a small control register. A controller drives a 3-bit operation code together with a data bus. With these it programs the counters and the mode, and it reads back the control register or either counter on a separate output bus.

While the count operation is presented, each pulse on the count strobe moves the address by one and steps the word counter by one. The control register picks the address direction and one of four end-of-transfer rules. When the selected rule is met, a registered done flag rises. The flag freezes both counters until the controller reloads a counter or restores both from their saved values.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset the address counter, the word counter, both saved values and the control register are zero, and `done` is low.
- R2: Operation code 0 stores `data_in[2:0]` in the control register and ignores `data_in[7:3]`. Bit 2 is the address direction (0 up, 1 down). Bits 1:0 are the end rule (0 last word, 1 word compare, 2 address compare, 3 word carry). Operation code 1 shows the stored bits on `data_out[2:0]`, with all higher bits zero.
- R3: `data_out` is combinational from the present operation code. Code 2 shows the word counter, code 3 shows the address counter, and codes 0 and 4 to 7 give zero.
- R4: Code 5 loads `data_in` into the address counter and its saved value. Code 6 loads it into the word counter and its saved value. Both take effect at the next clock edge and clear `done`.
- R5: A count step happens when the code is 7, `cnt_strobe` is high and `done` is low. It adds one to the address (direction 0) or subtracts one (direction 1), wrapping modulo 2^DATA_W. With no strobe, or under any other code, the address does not move.
- R6: On each count step the word counter decrements in end rule 0 and increments in end rules 1, 2 and 3.
- R7: End rule 0: a count step taken while the word counter holds one sets `done` at the same edge, and the word counter becomes zero.
- R8: End rule 1: a count step whose incremented word count equals the saved word-count value sets `done`.
- R9: End rule 2: a count step whose new address equals the saved word-count value sets `done`.
- R10: End rule 3: a count step taken while the word counter is all ones (carry out) sets `done`, and the word counter wraps to zero.
- R11: Once `done` is set it stays set and blocks all counting until code 4, 5 or 6 is applied.
- R12: Code 4 restores the address from its saved value and clears `done`. It sets the word counter to its saved value in end rules 0 and 3, and to zero in end rules 1 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 3 | Operation code |
| data_in | input | DATA_W | Load data for the control register and the counters |
| cnt_strobe | input | 1 | Count pulse, used under code 7 |
| data_out | output | DATA_W | Read-back data for codes 1 to 3 |
| addr_out | output | DATA_W | Present address counter value |
| done | output | 1 | Registered end-of-transfer flag |

## Verification
The read-back bus is combinational. Its value is therefore checked in the same cycle the read code is applied, one time unit after the inputs change and before the next edge. Loads, count steps, restores and the done flag are all due one edge after the cycle that carries the operation. The bench applies each operation at the falling edge and samples `addr_out` and `done` two time units after the following rising edge. It never samples at the edge itself.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;

   typedef enum logic [2:0] {
      OP_WR_CTRL = 3'd0,
      OP_RD_CTRL = 3'd1,
      OP_RD_WC   = 3'd2,
      OP_RD_ADDR = 3'd3,
      OP_REINIT  = 3'd4,
      OP_LD_ADDR = 3'd5,
      OP_LD_WC   = 3'd6,
      OP_COUNT   = 3'd7
   } op_e;

   typedef enum logic [1:0] {
      TM_LAST_WORD = 2'd0,
      TM_WC_CMP    = 2'd1,
      TM_ADDR_CMP  = 2'd2,
      TM_WC_CARRY  = 2'd3
   } term_e;

   localparam int CTRL_BITS = 3;

   typedef struct packed {
      logic  dir_down;
      term_e term;
   } ctrl_t;

endpackage

// File: rtl/dma_ag_ctrl.sv
module dma_ag_ctrl
   import dma_ag_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [CTRL_BITS-1:0] wr_bits,
   output ctrl_t                ctrl_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en) begin
         ctrl_q <= ctrl_t'(wr_bits);
      end
   end

endmodule

// File: rtl/dma_ag_cnt.sv
module dma_ag_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   input  logic         restore_en,
   input  logic         restore_zero,
   input  logic         step_en,
   input  logic         step_down,
   output logic [W-1:0] cnt_q,
   output logic [W-1:0] init_q
);

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] stepped;

   assign stepped = step_down ? (cnt_q - ONE) : (cnt_q + ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         init_q <= '0;
      end else if (load_en) begin
         cnt_q  <= load_val;
         init_q <= load_val;
      end else if (restore_en) begin
         cnt_q  <= restore_zero ? '0 : init_q;
      end else if (step_en) begin
         cnt_q  <= stepped;
      end
   end

endmodule

// File: rtl/dma_ag_term.sv
module dma_ag_term
   import dma_ag_pkg::*;
#(
   parameter int W = 16
) (
   input  term_e        mode,
   input  logic         dir_down,
   input  logic [W-1:0] addr_q,
   input  logic [W-1:0] wc_q,
   input  logic [W-1:0] wc_init,
   output logic         hit
);

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] addr_nxt;
   logic [W-1:0] wc_inc;

   assign addr_nxt = dir_down ? (addr_q - ONE) : (addr_q + ONE);
   assign wc_inc   = wc_q + ONE;

   always_comb begin
      unique case (mode)
         TM_LAST_WORD: hit = (wc_q == ONE);
         TM_WC_CMP:    hit = (wc_inc == wc_init);
         TM_ADDR_CMP:  hit = (addr_nxt == wc_init);
         TM_WC_CARRY:  hit = &wc_q;
         default:      hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
   import dma_ag_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        instr,
   input  logic [DATA_W-1:0] data_in,
   input  logic              cnt_strobe,
   output logic [DATA_W-1:0] data_out,
   output logic [DATA_W-1:0] addr_out,
   output logic              done
);

   localparam int PAD_W = DATA_W - CTRL_BITS;

   if (DATA_W < 8) begin : g_bad_width
      $error("dma_addr_gen: DATA_W must hold the 8-bit control byte");
   end

   op_e               op;
   ctrl_t             ctrl_q;
   logic              ctrl_dir;
   logic              step_ok;
   logic              hit;
   logic              wc_zero_on_restore;
   logic              wc_down;
   logic              clr_done;
   logic [DATA_W-1:0] addr_q, addr_init, wc_q, wc_init;
   logic [DATA_W-1:0] ctrl_rb;

   assign op       = op_e'(instr);
   assign ctrl_dir = ctrl_q.dir_down;
   assign step_ok  = (op == OP_COUNT) && cnt_strobe && !done;
   assign clr_done = (op == OP_REINIT) || (op == OP_LD_ADDR) || (op == OP_LD_WC);
   assign wc_zero_on_restore = (ctrl_q.term == TM_WC_CMP) || (ctrl_q.term == TM_ADDR_CMP);
   assign wc_down  = (ctrl_q.term == TM_LAST_WORD);

   dma_ag_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (op == OP_WR_CTRL),
      .wr_bits (data_in[CTRL_BITS-1:0]),
      .ctrl_q  (ctrl_q)
   );

   dma_ag_cnt #(.W(DATA_W)) u_addr (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_en      (op == OP_LD_ADDR),
      .load_val     (data_in),
      .restore_en   (op == OP_REINIT),
      .restore_zero (1'b0),
      .step_en      (step_ok),
      .step_down    (ctrl_dir),
      .cnt_q        (addr_q),
      .init_q       (addr_init)
   );

   dma_ag_cnt #(.W(DATA_W)) u_wc (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_en      (op == OP_LD_WC),
      .load_val     (data_in),
      .restore_en   (op == OP_REINIT),
      .restore_zero (wc_zero_on_restore),
      .step_en      (step_ok),
      .step_down    (wc_down),
      .cnt_q        (wc_q),
      .init_q       (wc_init)
   );

   dma_ag_term #(.W(DATA_W)) u_term (
      .mode     (ctrl_q.term),
      .dir_down (ctrl_dir),
      .addr_q   (addr_q),
      .wc_q     (wc_q),
      .wc_init  (wc_init),
      .hit      (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= 1'b0;
      end else if (clr_done) begin
         done <= 1'b0;
      end else if (step_ok && hit) begin
         done <= 1'b1;
      end
   end

   if (PAD_W > 0) begin : g_rb_pad
      assign ctrl_rb = {{PAD_W{1'b0}}, ctrl_q};
   end else begin : g_rb_flat
      assign ctrl_rb = ctrl_q;
   end

   always_comb begin
      unique case (op)
         OP_RD_CTRL: data_out = ctrl_rb;
         OP_RD_WC:   data_out = wc_q;
         OP_RD_ADDR: data_out = addr_q;
         default:    data_out = '0;
      endcase
   end

   assign addr_out = addr_q;

   logic unused_ok;
   assign unused_ok = ^addr_init;

endmodule

// File: rtl/dma_ag_chk.sv
module dma_ag_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        instr,
   input logic [DATA_W-1:0] data_in,
   input logic              cnt_strobe,
   input logic [DATA_W-1:0] addr_out,
   input logic              done,
   input logic              dir
);

   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   p_load_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (instr == 3'd5) |=> (addr_out == $past(data_in)));

   p_step_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (instr == 3'd7 && cnt_strobe && !done && !dir) |=> (addr_out == $past(addr_out) + ONE));

   p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (instr == 3'd7 && cnt_strobe && !done && dir) |=> (addr_out == $past(addr_out) - ONE));

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (instr <= 3'd3) |=> ($stable(addr_out) && $stable(done)));

   p_done_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (instr == 3'd7 || instr <= 3'd3)) |=> (done && $stable(addr_out)));

   p_reinit_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (instr == 3'd4) |=> !done);

endmodule

bind dma_addr_gen dma_ag_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .instr      (instr),
   .data_in    (data_in),
   .cnt_strobe (cnt_strobe),
   .addr_out   (addr_out),
   .done       (done),
   .dir        (ctrl_dir)
);

// File: tb/sim_dma_addr_gen.sv
`timescale 1ns/1ps
module sim_dma_addr_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  instr = 3'd3;
   logic [15:0] data_in = '0;
   logic        strobe = 1'b0;
   logic [15:0] data_out, addr_out;
   logic        done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dma_addr_gen #(.DATA_W(16)) u0 (
      .clk(clk), .rst_n(rst_n), .instr(instr), .data_in(data_in),
      .cnt_strobe(strobe), .data_out(data_out), .addr_out(addr_out), .done(done)
   );

   // row: {op, data, strobe, expected address, expected done}
   localparam int NV = 11;
   localparam logic [36:0] VEC [NV] = '{
      {3'd5, 16'h0100, 1'b0, 16'h0100, 1'b0},   // R4 load address
      {3'd6, 16'h0003, 1'b0, 16'h0100, 1'b0},   // R4 load count 3
      {3'd7, 16'h0000, 1'b1, 16'h0101, 1'b0},   // R5 step, wc 2
      {3'd7, 16'h0000, 1'b0, 16'h0101, 1'b0},   // R5 no strobe
      {3'd7, 16'h0000, 1'b1, 16'h0102, 1'b0},   // R6 wc 1
      {3'd7, 16'h0000, 1'b1, 16'h0103, 1'b1},   // R7 last word
      {3'd7, 16'h0000, 1'b1, 16'h0103, 1'b1},   // R11 blocked
      {3'd4, 16'h0000, 1'b0, 16'h0100, 1'b0},   // R12 restore
      {3'd0, 16'h0004, 1'b0, 16'h0100, 1'b0},   // R2 direction down
      {3'd7, 16'h0000, 1'b1, 16'h00FF, 1'b0},   // R5 decrement
      {3'd3, 16'h0000, 1'b1, 16'h00FF, 1'b0}    // R5 strobe under read
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic [2:0] op, input logic [15:0] d, input logic s);
      @(negedge clk);
      instr = op; data_in = d; strobe = s;
      @(posedge clk);
      #2;
   endtask

   task automatic rd(input logic [2:0] op, input string req, input logic [15:0] exp);
      @(negedge clk);
      instr = op; strobe = 1'b0;
      #1;
      chk(req, {16'h0, data_out}, {16'h0, exp});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 address", {16'h0, addr_out}, 32'h0);
      chk("R1 done", {31'h0, done}, 32'h0);
      rd(3'd2, "R1 word counter", 16'h0000);
      rd(3'd1, "R1 control", 16'h0000);

      for (int i = 0; i < NV; i++) begin
         cyc(VEC[i][36:34], VEC[i][33:18], VEC[i][17]);
         chk($sformatf("R5 table row %0d address", i), {16'h0, addr_out}, {16'h0, VEC[i][16:1]});
         chk($sformatf("R7 table row %0d done", i), {31'h0, done}, {31'h0, VEC[i][0]});
      end

      rd(3'd2, "R6 word count after down-step", 16'h0002);
      rd(3'd7, "R3 zero for non-read code", 16'h0000);
      rd(3'd3, "R3 address read", 16'h00FF);

      cyc(3'd0, 16'h00FD, 1'b0);
      rd(3'd1, "R2 upper bits ignored", 16'h0005);

      // end rule 1
      cyc(3'd0, 16'h0001, 1'b0);
      cyc(3'd5, 16'h0010, 1'b0);
      cyc(3'd6, 16'h0003, 1'b0);
      cyc(3'd4, 16'h0000, 1'b0);
      rd(3'd2, "R12 word counter zeroed", 16'h0000);
      cyc(3'd7, 16'h0000, 1'b1);
      cyc(3'd7, 16'h0000, 1'b1);
      chk("R8 not yet done", {31'h0, done}, 32'h0);
      cyc(3'd7, 16'h0000, 1'b1);
      chk("R8 done", {31'h0, done}, 32'h1);
      chk("R8 address", {16'h0, addr_out}, 32'h13);
      rd(3'd2, "R6 word counter counted up", 16'h0003);

      // end rule 2
      cyc(3'd0, 16'h0002, 1'b0);
      cyc(3'd6, 16'h0022, 1'b0);
      chk("R4 load clears done", {31'h0, done}, 32'h0);
      cyc(3'd5, 16'h0020, 1'b0);
      cyc(3'd7, 16'h0000, 1'b1);
      chk("R9 not yet done", {31'h0, done}, 32'h0);
      cyc(3'd7, 16'h0000, 1'b1);
      chk("R9 done", {31'h0, done}, 32'h1);
      chk("R9 address", {16'h0, addr_out}, 32'h22);
      cyc(3'd7, 16'h0000, 1'b1);
      chk("R11 address frozen", {16'h0, addr_out}, 32'h22);
      chk("R11 done held", {31'h0, done}, 32'h1);

      // end rule 3
      cyc(3'd0, 16'h0003, 1'b0);
      cyc(3'd6, 16'hFFFE, 1'b0);
      chk("R4 load count clears done", {31'h0, done}, 32'h0);
      cyc(3'd7, 16'h0000, 1'b1);
      chk("R10 not yet done", {31'h0, done}, 32'h0);
      cyc(3'd7, 16'h0000, 1'b1);
      chk("R10 done", {31'h0, done}, 32'h1);
      rd(3'd2, "R10 word counter wrapped", 16'h0000);

      // address wrap both ways
      cyc(3'd0, 16'h0000, 1'b0);
      cyc(3'd5, 16'hFFFF, 1'b0);
      cyc(3'd6, 16'h0005, 1'b0);
      cyc(3'd7, 16'h0000, 1'b1);
      chk("R5 wrap up", {16'h0, addr_out}, 32'h0);
      cyc(3'd0, 16'h0004, 1'b0);
      cyc(3'd5, 16'h0000, 1'b0);
      cyc(3'd7, 16'h0000, 1'b1);
      chk("R5 wrap down", {16'h0, addr_out}, 32'hFFFF);
      chk("R7 no early done", {31'h0, done}, 32'h0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule